// File: doc/BRIEF.md
# Staged Bias-Supply Power-Up Sequencer

This controller brings up the bias rails of a display panel one stage at a time. A repeated ramp timer stands in for the charge and discharge cycles of an external delay capacitor. Each stage of the bring-up lasts one ramp. The first ramp is slow: it is stretched by a multiplier over the others. The controller starts only when the input supply is good and the enable input is high. It then walks through six ramps. It turns on the reference, the boost soft-start, the negative rail and the positive rail in a fixed order, and it samples the rail power-good flags at the ramp ends where each rail must have settled.

Once the six ramps finish, the controller enters its running state. There it hands the gate-slice switch selector to an external select input. It also watches the power-good flags through a persistence timer whose length scales with the ramp length. A fault from any source turns every enable off, grounds the switch and latches. An over-temperature flag, a failed ramp-end check or a flag that stays low in the running state are all faults. The latch releases only when the enable input goes low or the supply-good flag drops. A sticky cause register tells which check failed.

Top module: `bias_seq_ctrl`

## Requirements
- R1: While `supply_good` or `enable` is low, the phase stays idle (code 0), all four rail enables are low and `fault_cause` is unchanged.
- R2: After a start, phase advances 1,2,3,4,5,6 and then 7 (running). Phase 1 lasts SLOW_MULT*RAMP_CYC clock cycles. Phases 2 to 6 each last RAMP_CYC cycles.
- R3: `ref_en` is high from phase 2, `boost_en` from phase 3, `neg_en` from phase 4 and `pos_en` from phase 6. All of them stay high in phase 7. Each enable is high only when every earlier one is high.
- R4: `gate_sw_sel` is 0 (ground) in every phase other than 7. In phase 7 it is 1 (lower path) when `slice_sel_in` is 0 and 2 (upper path) when it is 1, and it follows a change of the input one cycle later.
- R5: If `pg_boost` is low in the last cycle of phase 3, the next phase is 8 (fault) and `fault_cause` bit 1 is set.
- R6: If `pg_neg` or `pg_pos` is low in the last cycle of phase 6, the next phase is 8. `fault_cause` bit 2 records a low `pg_neg` and bit 3 records a low `pg_pos`. Power-good flags are ignored at every other point of phases 1 to 6.
- R7: A high `ot_flag` in any of phases 1 to 7 moves the controller to phase 8 on the next clock edge and sets `fault_cause` bit 0.
- R8: In phase 7, if any power-good flag is low for FAULT_RAMPS*RAMP_CYC consecutive cycles, the controller enters phase 8 and sets the cause bits of the low flags. A shorter dip has no effect.
- R9: In phase 8, all enables are low and `gate_sw_sel` is 0, regardless of the flags and the select input. The controller leaves phase 8 only for idle, and only when `enable` or `supply_good` goes low.
- R10: `fault_cause` keeps its bits through the return to idle. It is cleared to 0 on the edge that starts a new sequence.
- R11: If `enable` or `supply_good` goes low in phases 1 to 7, the controller returns to idle on the next edge with every output off and no cause bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_good | input | 1 | Input supply above the lockout level |
| enable | input | 1 | Master enable; toggling low clears a fault |
| slice_sel_in | input | 1 | Gate-slice path select once running |
| pg_boost | input | 1 | Boost rail power-good |
| pg_neg | input | 1 | Negative rail power-good |
| pg_pos | input | 1 | Positive rail power-good |
| ot_flag | input | 1 | Over-temperature flag |
| ref_en | output | 1 | Reference enable |
| boost_en | output | 1 | Boost soft-start enable |
| neg_en | output | 1 | Negative rail enable |
| pos_en | output | 1 | Positive rail enable |
| gate_sw_sel | output | 2 | Switch selector: 0 ground, 1 lower path, 2 upper path |
| phase | output | 4 | 0 idle, 1..6 ramp, 7 running, 8 fault |
| fault_cause | output | 4 | Sticky cause: bit0 temperature, bit1 boost, bit2 negative, bit3 positive |

## Verification
A clean bring-up with all flags high checks the ramp boundaries and the enable order one cycle either side of each step. Then the sequence is rerun with a single flag held low, which shows that each check point samples its own rail and only at its own ramp end. In the running state, a flag dip one cycle short of the timeout is contrasted with one that lasts the full timeout, and a one-cycle over-temperature pulse is contrasted with a dropped enable. This separates a latched fault from a plain abort. The recovery patterns toggle the enable and cycle the supply, and confirm that the cause bits survive into idle and clear on the next start.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE  = 4'd0,
    PH_R1    = 4'd1,
    PH_R2    = 4'd2,
    PH_R3    = 4'd3,
    PH_R4    = 4'd4,
    PH_R5    = 4'd5,
    PH_R6    = 4'd6,
    PH_RUN   = 4'd7,
    PH_FAULT = 4'd8
  } phase_e;

  typedef enum logic [1:0] {
    SW_GND = 2'd0,
    SW_LO  = 2'd1,
    SW_HI  = 2'd2
  } sw_e;

  localparam int CB_OT    = 0;
  localparam int CB_BOOST = 1;
  localparam int CB_NEG   = 2;
  localparam int CB_POS   = 3;
  localparam int N_RAILS  = 4;

endpackage

// File: rtl/ramp_timer.sv
module ramp_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] len,
  output logic          peak
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // peak marks the final cycle of a ramp
  assign peak = (cnt == len - 1'b1);
endmodule

// File: rtl/fault_timer.sv
module fault_timer #(
  parameter int CW    = 8,
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic bad,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !(arm && bad)) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign expired = arm && bad && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/seq_outputs.sv
module seq_outputs
  import bias_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  phase_e               nxt,
  input  logic                 slice_sel_in,
  output logic [N_RAILS-1:0]   rail_en,   // [0] ref [1] boost [2] neg [3] pos
  output logic [1:0]           sw_sel
);
  function automatic phase_e on_phase(int idx);
    case (idx)
      0:       on_phase = PH_R2;
      1:       on_phase = PH_R3;
      2:       on_phase = PH_R4;
      default: on_phase = PH_R6;
    endcase
  endfunction

  for (genvar gi = 0; gi < N_RAILS; gi++) begin : g_rail
    always_ff @(posedge clk) begin
      if (rst) rail_en[gi] <= 1'b0;
      else     rail_en[gi] <= (nxt >= on_phase(gi)) && (nxt <= PH_RUN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                sw_sel <= SW_GND;
    else if (nxt == PH_RUN) sw_sel <= slice_sel_in ? SW_HI : SW_LO;
    else                    sw_sel <= SW_GND;
  end

  // R3: rails come up strictly in order
  a_r3_rail_order: assert property (@(posedge clk) disable iff (rst)
    (rail_en[3] |-> rail_en[2]) and (rail_en[2] |-> rail_en[1]) and (rail_en[1] |-> rail_en[0]));
endmodule

// File: rtl/bias_seq_ctrl.sv
module bias_seq_ctrl
  import bias_seq_pkg::*;
#(
  parameter int RAMP_CYC    = 875000,
  parameter int SLOW_MULT   = 2,
  parameter int FAULT_RAMPS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_good,
  input  logic       enable,
  input  logic       slice_sel_in,
  input  logic       pg_boost,
  input  logic       pg_neg,
  input  logic       pg_pos,
  input  logic       ot_flag,
  output logic       ref_en,
  output logic       boost_en,
  output logic       neg_en,
  output logic       pos_en,
  output logic [1:0] gate_sw_sel,
  output logic [3:0] phase,
  output logic [3:0] fault_cause
);
  localparam int RAMP1_CYC = RAMP_CYC * SLOW_MULT;
  localparam int FAULT_CYC = RAMP_CYC * FAULT_RAMPS;
  localparam int MAX_CYC   = (RAMP1_CYC > FAULT_CYC) ? RAMP1_CYC : FAULT_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  phase_e             st, nxt;
  logic               clr, peak, expired, go;
  logic [CW-1:0]      ramp_len;
  logic [3:0]         cause_q, cause_set;
  logic [N_RAILS-1:0] rail_en;
  logic               active;

  assign go       = enable && supply_good;
  assign active   = (st >= PH_R1) && (st <= PH_RUN);
  assign ramp_len = (st == PH_R1) ? CW'(RAMP1_CYC) : CW'(RAMP_CYC);

  ramp_timer #(.CW(CW)) u_ramp (
    .clk(clk), .rst(rst), .clr(clr), .len(ramp_len), .peak(peak)
  );

  fault_timer #(.CW(CW), .LIMIT(FAULT_CYC)) u_ftmr (
    .clk(clk), .rst(rst), .arm(st == PH_RUN),
    .bad(!(pg_boost && pg_neg && pg_pos)), .expired(expired)
  );

  always_comb begin
    nxt       = st;
    clr       = 1'b0;
    cause_set = 4'b0000;
    if (st == PH_IDLE) begin
      clr = 1'b1;
      if (go) nxt = PH_R1;
    end else if (st == PH_FAULT) begin
      clr = 1'b1;
      if (!go) nxt = PH_IDLE;
    end else if (!go) begin
      clr = 1'b1;
      nxt = PH_IDLE;
    end else if (ot_flag) begin
      clr              = 1'b1;
      nxt              = PH_FAULT;
      cause_set[CB_OT] = 1'b1;
    end else if (st == PH_RUN) begin
      clr = 1'b1;
      if (expired) begin
        nxt                 = PH_FAULT;
        cause_set[CB_BOOST] = !pg_boost;
        cause_set[CB_NEG]   = !pg_neg;
        cause_set[CB_POS]   = !pg_pos;
      end
    end else if (peak) begin
      clr = 1'b1;
      if (st == PH_R3 && !pg_boost) begin
        nxt                 = PH_FAULT;
        cause_set[CB_BOOST] = 1'b1;
      end else if (st == PH_R6 && !(pg_neg && pg_pos)) begin
        nxt               = PH_FAULT;
        cause_set[CB_NEG] = !pg_neg;
        cause_set[CB_POS] = !pg_pos;
      end else begin
        nxt = phase_e'(4'(st + 4'd1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= PH_IDLE;
    else     st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                                cause_q <= 4'b0000;
    else if (st == PH_IDLE && nxt == PH_R1) cause_q <= 4'b0000;
    else                                    cause_q <= cause_q | cause_set;
  end

  seq_outputs u_out (
    .clk(clk), .rst(rst), .nxt(nxt), .slice_sel_in(slice_sel_in),
    .rail_en(rail_en), .sw_sel(gate_sw_sel)
  );

  assign ref_en      = rail_en[0];
  assign boost_en    = rail_en[1];
  assign neg_en      = rail_en[2];
  assign pos_en      = rail_en[3];
  assign phase       = st;
  assign fault_cause = cause_q;

  // R4: switch grounded outside the running phase
  a_r4_sw_ground: assert property (@(posedge clk) disable iff (rst)
    (gate_sw_sel != 2'd0) |-> (st == PH_RUN));

  // R5: failed boost check at the end of ramp 3 latches
  a_r5_boost_check: assert property (@(posedge clk) disable iff (rst)
    (st == PH_R3 && peak && !pg_boost && go && !ot_flag) |=> (st == PH_FAULT && cause_q[CB_BOOST]));

  // R7: over-temperature latches on the next edge
  a_r7_overtemp: assert property (@(posedge clk) disable iff (rst)
    (active && go && ot_flag) |=> (st == PH_FAULT && cause_q[CB_OT]));

  // R9: everything off while faulted
  a_r9_fault_off: assert property (@(posedge clk) disable iff (rst)
    (st == PH_FAULT) |-> (rail_en == '0 && gate_sw_sel == 2'd0));

  // R10: cause bits only clear when a new sequence starts from idle
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (st != PH_IDLE) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: tb/tb_bias_seq_ctrl.sv
module tb_bias_seq_ctrl;
  localparam int RC    = 8;
  localparam int SM    = 2;
  localparam int FR    = 3;
  localparam int R1C   = RC * SM;
  localparam int FC    = RC * FR;
  localparam int T_R2  = R1C;
  localparam int T_R3  = R1C + RC;
  localparam int T_R4  = R1C + 2 * RC;
  localparam int T_R5  = R1C + 3 * RC;
  localparam int T_R6  = R1C + 4 * RC;
  localparam int T_RUN = R1C + 5 * RC;

  logic clk = 1'b0;
  logic rst, supply_good, enable, slice_sel_in, pg_boost, pg_neg, pg_pos, ot_flag;
  logic ref_en, boost_en, neg_en, pos_en;
  logic [1:0] gate_sw_sel;
  logic [3:0] phase, fault_cause;

  bias_seq_ctrl #(.RAMP_CYC(RC), .SLOW_MULT(SM), .FAULT_RAMPS(FR)) dut (
    .clk(clk), .rst(rst), .supply_good(supply_good), .enable(enable),
    .slice_sel_in(slice_sel_in), .pg_boost(pg_boost), .pg_neg(pg_neg),
    .pg_pos(pg_pos), .ot_flag(ot_flag), .ref_en(ref_en), .boost_en(boost_en),
    .neg_en(neg_en), .pos_en(pos_en), .gate_sw_sel(gate_sw_sel),
    .phase(phase), .fault_cause(fault_cause)
  );

  always #4 clk = ~clk;

  logic [13:0] exp_q[$];
  string       tag_q[$];
  int n_chk = 0, n_bad = 0, rel = 0;
  bit done = 0;

  // expected enables {ref, boost, neg, pos} for a phase code
  function automatic logic [3:0] en_for(int ph);
    if (ph < 2 || ph > 7) return 4'b0000;
    return {1'b1, ph >= 3, ph >= 4, ph >= 6};
  endfunction

  task automatic expect_st(int ph, logic [1:0] sw, logic [3:0] cause, string tag);
    exp_q.push_back({4'(ph), en_for(ph), sw, cause});
    tag_q.push_back(tag);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
    rel += n;
  endtask

  task automatic adv(int t);
    step(t - rel);
  endtask

  task automatic start_seq;
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(1);
    rel = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [13:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {phase, ref_en, boost_en, neg_en, pos_en, gate_sw_sel, fault_cause};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual ph=%0d en=%b sw=%0d cause=%b expected ph=%0d en=%b sw=%0d cause=%b",
                 t, a[13:10], a[9:6], a[5:4], a[3:0], e[13:10], e[9:6], e[5:4], e[3:0]);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; supply_good = 1'b0; enable = 1'b0; slice_sel_in = 1'b0;
    pg_boost = 1'b0; pg_neg = 1'b0; pg_pos = 1'b0; ot_flag = 1'b0;
    step(3);
    expect_st(0, 2'd0, 4'b0000, "R1 reset state");
    rst = 1'b0;
    supply_good = 1'b1;
    step(4);
    expect_st(0, 2'd0, 4'b0000, "R1 supply good, enable low");
    enable = 1'b1; supply_good = 1'b0;
    step(3);
    expect_st(0, 2'd0, 4'b0000, "R1 enable high, supply low");

    // clean bring-up
    supply_good = 1'b1; pg_boost = 1'b1; pg_neg = 1'b1; pg_pos = 1'b1;
    start_seq();
    expect_st(1, 2'd0, 4'b0000, "R2 first ramp entered");
    adv(T_R2 - 1); expect_st(1, 2'd0, 4'b0000, "R2 slow ramp length");
    adv(T_R2);     expect_st(2, 2'd0, 4'b0000, "R3 reference after first peak");
    adv(T_R3);     expect_st(3, 2'd0, 4'b0000, "R3 boost soft-start");
    adv(T_R4);     expect_st(4, 2'd0, 4'b0000, "R3 negative rail");
    adv(T_R5);     expect_st(5, 2'd0, 4'b0000, "R2 ramp five");
    adv(T_R6 - 1); expect_st(5, 2'd0, 4'b0000, "R2 normal ramp length");
    adv(T_R6);     expect_st(6, 2'd0, 4'b0000, "R3 positive rail");
    adv(T_RUN - 1);expect_st(6, 2'd0, 4'b0000, "R2 last ramp");
    adv(T_RUN);    expect_st(7, 2'd1, 4'b0000, "R4 running lower path");
    slice_sel_in = 1'b1; step(1); expect_st(7, 2'd2, 4'b0000, "R4 upper path");
    slice_sel_in = 1'b0; step(1); expect_st(7, 2'd1, 4'b0000, "R4 back to lower path");

    // short dip then persistent loss
    pg_pos = 1'b0; step(FC - 1); pg_pos = 1'b1; step(2);
    expect_st(7, 2'd1, 4'b0000, "R8 short dip ignored");
    pg_neg = 1'b0; step(FC - 1);
    expect_st(7, 2'd1, 4'b0000, "R8 before timeout");
    step(1);
    expect_st(8, 2'd0, 4'b0100, "R8 timeout latches");
    pg_neg = 1'b1; slice_sel_in = 1'b1; step(5);
    expect_st(8, 2'd0, 4'b0100, "R9 latch holds after recovery");
    enable = 1'b0; step(1);
    expect_st(0, 2'd0, 4'b0100, "R10 cause kept in idle");
    enable = 1'b1; step(1); rel = 0;
    expect_st(1, 2'd0, 4'b0000, "R10 cause cleared on start");

    // boost fails its check
    pg_boost = 1'b0;
    adv(T_R4 - 1); expect_st(3, 2'd0, 4'b0000, "R5 before boost check");
    adv(T_R4);     expect_st(8, 2'd0, 4'b0010, "R5 boost check fails");
    supply_good = 1'b0; step(1);
    expect_st(0, 2'd0, 4'b0010, "R9 supply drop clears latch");
    supply_good = 1'b1;

    // positive rail fails
    pg_boost = 1'b1; pg_pos = 1'b0;
    start_seq();
    adv(T_R5);  expect_st(5, 2'd0, 4'b0000, "R6 early low flag ignored");
    adv(T_RUN); expect_st(8, 2'd0, 4'b1000, "R6 positive check fails");

    // both rails fail
    pg_neg = 1'b0;
    start_seq();
    expect_st(1, 2'd0, 4'b0000, "R10 restart clears");
    adv(T_RUN); expect_st(8, 2'd0, 4'b1100, "R6 both checks fail");

    // over-temperature in a ramp
    pg_neg = 1'b1; pg_pos = 1'b1;
    start_seq();
    adv(T_R4 + 3); ot_flag = 1'b1; step(1);
    expect_st(8, 2'd0, 4'b0001, "R7 temperature in ramp");
    ot_flag = 1'b0; step(2);
    expect_st(8, 2'd0, 4'b0001, "R9 stays faulted");

    // over-temperature while running
    start_seq();
    adv(T_RUN + 2); expect_st(7, 2'd2, 4'b0000, "R4 running with upper select");
    ot_flag = 1'b1; step(1);
    expect_st(8, 2'd0, 4'b0001, "R7 temperature while running");
    ot_flag = 1'b0;

    // aborts
    start_seq();
    adv(T_R5 + 2); enable = 1'b0; step(1);
    expect_st(0, 2'd0, 4'b0000, "R11 enable drop mid sequence");
    enable = 1'b1; step(1); rel = 0;
    adv(T_RUN + 1); expect_st(7, 2'd2, 4'b0000, "R2 rerun reaches running");
    supply_good = 1'b0; step(1);
    expect_st(0, 2'd0, 4'b0000, "R11 supply drop while running");

    step(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule